// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block computes a signed FIR dot product without a single multiplier. Samples enter a tap delay line. The block then walks through the bit positions of the stored samples. At each bit position, the bits taken from all taps form an address into small precomputed tables. Each table entry is the sum of the coefficients whose address bit is set. The table outputs for one group of bit positions are summed and folded into an accumulator, most significant group first. The group that holds the two's-complement sign bit is given negative weight.

The taps are split into table partitions of `PSZ` taps each, and each partition has its own table of `2**PSZ` entries. `PSZ` may be at most 12. The `RADIX` parameter sets how many bits are handled per clock: `log2(RADIX)` bits per clock, so a result takes `W/log2(RADIX)` cycles. `RADIX=2` is the fully serial default and `RADIX=2**W` is fully parallel. `RADIX` must be a power of two, and `log2(RADIX)` must divide `W`. Any other setting stops elaboration. The table contents are computed at elaboration from the `COEFS` parameter, with tap 0 in the least significant `CW` bits.

Top module: `da_fir`

## Requirements
- R1: Each result equals the exact sum over k of c_k·x[n−k], where x[n] is the newest accepted sample. Samples are signed W-bit two's complement, coefficients are signed CW-bit, and the result is a signed OW-bit value.
- R2: A sample on `in_data` is accepted when `in_valid` is high and the block is idle. It is also accepted during the final computation cycle of the previous result.
- R3: `out_valid` is high for exactly one cycle, W/log2(RADIX) clock edges after the edge that accepted the sample. With W=8 this is 8 edges at RADIX=2 and 2 edges at RADIX=16.
- R4: A pulse on `in_valid` during any computation cycle except the final one is ignored. The sample does not enter the delay line.
- R5: Samples accepted back to back, every W/log2(RADIX) cycles, produce one result every W/log2(RADIX) cycles with no gap.
- R6: `out_data` keeps its last result unchanged while `out_valid` is low.
- R7: `out_valid` is never raised unless a computation was in progress on the previous cycle.
- R8: After reset, `out_valid` and `out_data` are 0 and every tap holds zero. The first result after reset therefore sees no older samples.
- R9: Results stay exact when every tap holds the most negative value −2^(W−1) or the most positive value 2^(W−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe offering a new sample |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OW | Signed filter result |

## Verification
The hardest case to reach is an `in_valid` pulse that lands exactly on the final computation cycle. That pulse must be accepted. A pulse one cycle earlier must be dropped. The stimulus places strobes at controlled spacings: the exact result period, one cycle short of it, and a few cycles into a computation. A randomly spaced stream is then mixed in, so that both acceptance and rejection happen many times. Two instances run side by side, one fully serial and one with four bits per clock, so the same strobes fall at different phases of each instance's computation.

// File: rtl/da_fir.sv
module da_fir #(
  parameter int W     = 8,
  parameter int NTAPS = 6,
  parameter int CW    = 8,
  parameter int PSZ   = 3,
  parameter int RADIX = 2,
  parameter logic [NTAPS*CW-1:0] COEFS = 48'h09_80_7F_2D_EF_03,
  parameter int OW    = W + CW + $clog2(NTAPS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int B     = $clog2(RADIX);
  localparam int BS    = (B > 0) ? B : 1;
  localparam int NDIG  = W / BS;
  localparam int NPART = (NTAPS + PSZ - 1) / PSZ;
  localparam int TW    = CW + $clog2(PSZ) + 1;
  localparam int TSZ   = 1 << PSZ;
  localparam int CNW   = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int IXW   = (W > 1) ? $clog2(W) : 1;

  if (RADIX < 2 || (1 << B) != RADIX || (W % BS) != 0 || PSZ < 1 || PSZ > 12) begin : g_bad_cfg
    $error("da_fir: illegal RADIX/PSZ setting");
  end

  function automatic logic signed [TW-1:0] part_sum(int p, int a);
    logic signed [TW-1:0] s;
    s = '0;
    for (int k = 0; k < PSZ; k++)
      if (a[k] && (p * PSZ + k) < NTAPS)
        s += TW'($signed(COEFS[(p*PSZ+k)*CW +: CW]));
    return s;
  endfunction

  logic signed [TW-1:0] tbl [NPART][TSZ];
  for (genvar gp = 0; gp < NPART; gp++) begin : g_tbl
    for (genvar ga = 0; ga < TSZ; ga++) begin : g_ent
      assign tbl[gp][ga] = part_sum(gp, ga);
    end
  end

  logic [W-1:0]         tap_q [NTAPS];
  logic                 busy_q;
  logic [CNW-1:0]       cnt_q;
  logic signed [OW-1:0] acc_q;

  wire [CNW-1:0] dig    = CNW'(NDIG - 1) - cnt_q;
  wire           last   = (cnt_q == CNW'(NDIG - 1));
  wire           accept = in_valid && (!busy_q || last);

  logic [PSZ-1:0] addr [BS][NPART];
  for (genvar gb = 0; gb < BS; gb++) begin : g_bit
    wire [IXW-1:0] pos = IXW'(int'(dig) * BS + gb);
    for (genvar gp = 0; gp < NPART; gp++) begin : g_prt
      for (genvar gk = 0; gk < PSZ; gk++) begin : g_tap
        if (gp * PSZ + gk < NTAPS) begin : g_live
          assign addr[gb][gp][gk] = tap_q[gp*PSZ+gk][pos];
        end else begin : g_pad
          assign addr[gb][gp][gk] = 1'b0;
        end
      end
    end
  end

  logic signed [OW-1:0] dsum, term;
  always_comb begin
    dsum = '0;
    term = '0;
    for (int b = 0; b < BS; b++) begin
      for (int p = 0; p < NPART; p++) begin
        term = OW'(tbl[p][addr[b][p]]) <<< b;
        if (b == BS - 1 && cnt_q == '0) dsum -= term;
        else                            dsum += term;
      end
    end
  end

  wire signed [OW-1:0] acc_nx = ((cnt_q == '0) ? '0 : (acc_q <<< BS)) + dsum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy_q) begin
        acc_q <= acc_nx;
        cnt_q <= cnt_q + CNW'(1);
        if (last) begin
          out_valid <= 1'b1;
          out_data  <= acc_nx;
          busy_q    <= 1'b0;
        end
      end
      if (accept) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        tap_q[0] <= in_data;
        for (int i = NTAPS - 1; i > 0; i--) tap_q[i] <= tap_q[i-1];
      end
    end
  end

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int OW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic          last,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);

  a_r2_idle_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid) |=> busy);

  a_r4_ignore_midway: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && in_valid) |=> busy);

  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r7_valid_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));

  a_r3_finish_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> out_valid);

endmodule

bind da_fir da_fir_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy_q),
  .last(last), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/da_fir_tb_top.sv
module da_fir_tb_top;
  localparam int OW = 20;
  localparam int NT = 6;
  localparam int QD = 1024;
  localparam int CF [NT] = '{3, -17, 45, 127, -128, 9};
  localparam int ND [2] = '{8, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic va = 1'b0, vq = 1'b0;
  logic [7:0] in_data = '0;
  logic ov_a, ov_q;
  logic [OW-1:0] od_a, od_q;

  always #5 clk = ~clk;

  da_fir #(.RADIX(2))  dut_i (.clk(clk), .rst_n(rst_n), .in_valid(va), .in_data(in_data),
                              .out_valid(ov_a), .out_data(od_a));
  da_fir #(.RADIX(16)) dut_q (.clk(clk), .rst_n(rst_n), .in_valid(vq), .in_data(in_data),
                              .out_valid(ov_q), .out_data(od_q));

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  int dl [2][NT];
  longint ev [2][QD];
  int ec [2][QD];
  int wr [2], rd [2], nxt [2];
  longint last_out [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_dot(int d);
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(CF[k]) * longint'(dl[d][k]);
    return s;
  endfunction

  task automatic mon(int d, logic ov, logic [OW-1:0] od);
    longint v = longint'($signed(od));
    if (ov) begin
      if (rd[d] == wr[d]) chk(1'b0, "R7 unexpected out_valid", 1, 0);
      else begin
        chk(v == ev[d][rd[d] % QD], "R1,R4,R9 result", v, ev[d][rd[d] % QD]);
        chk(cyc == ec[d][rd[d] % QD], "R3,R5 result cycle", cyc, ec[d][rd[d] % QD]);
        rd[d]++;
      end
      last_out[d] = v;
    end else begin
      chk(v == last_out[d], "R6 held result", v, last_out[d]);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    mon(0, ov_a, od_a);
    mon(1, ov_q, od_q);
  end

  task automatic send(bit [1:0] mask, logic [7:0] x, int gap);
    in_data = x;
    va = mask[0];
    vq = mask[1];
    for (int d = 0; d < 2; d++) begin
      if (mask[d] && cyc + 1 >= nxt[d]) begin
        for (int k = NT - 1; k > 0; k--) dl[d][k] = dl[d][k-1];
        dl[d][0] = int'($signed(x));
        ev[d][wr[d] % QD] = ref_dot(d);
        ec[d][wr[d] % QD] = cyc + 1 + ND[d];
        wr[d]++;
        nxt[d] = cyc + 1 + ND[d];
      end
    end
    @(negedge clk);
    va = 1'b0;
    vq = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++) begin
      wr[d] = 0; rd[d] = 0; nxt[d] = 0; last_out[d] = 0;
      for (int k = 0; k < NT; k++) dl[d][k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(ov_a == 1'b0 && ov_q == 1'b0, "R8 reset out_valid", ov_a, 0);
    chk(od_a == '0 && od_q == '0, "R8 reset out_data", longint'($signed(od_a)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: impulse after reset exposes each coefficient with zero history
    send(2'b11, 8'd1, 8);
    for (int i = 0; i < NT; i++) send(2'b11, 8'd0, 8);
    // R9: extremes on every tap
    for (int i = 0; i < NT; i++) send(2'b11, 8'h80, 8);
    for (int i = 0; i < NT; i++) send(2'b11, 8'h7F, 8);
    for (int i = 0; i < NT; i++) send(2'b11, (i % 2) ? 8'h80 : 8'h7F, 8);
    // R4: strobe three cycles into a computation, then one cycle short
    send(2'b11, 8'd77, 3);
    send(2'b01, 8'hC3, 5);
    send(2'b11, 8'd19, 7);
    send(2'b11, 8'hA5, 8);
    send(2'b11, 8'd5, 9);
    // R2 R5: back to back at the exact period of the fast instance
    for (int i = 0; i < 10; i++) send(2'b10, 8'($urandom), 2);
    for (int i = 0; i < 150; i++) send(2'b11, 8'($urandom), int'($urandom_range(1, 10)));
    repeat (30) @(negedge clk);
    for (int d = 0; d < 2; d++)
      chk(rd[d] == wr[d], "R2 every accepted sample produced a result", rd[d], wr[d]);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule